// File: doc/BRIEF.md
# Pattern-Stepped Skipping Counter

This block is a free-running counter that avoids chosen residues without any divisibility test. On each advancing cycle it adds a small step value, taken from the front of a circular store of steps, and then rotates that store by one place. The default store holds alternating steps of one and two, so the count never lands on a multiple of three: 1, 2, 4, 5, 7, 8, 10, and so on. The only arithmetic is one adder, so the critical path is about as long as that of an ordinary incrementer.

A pattern port lets the user replace the stored steps and the count in a single clock. For example, steps of +1, +1, +1, +2 with a start of 1 skip every multiple of five. An enable input halts both the count and the rotation together, so the step phase always stays matched to the value shown.

Top module: `skip_counter`

## Requirements
- R1: While `rst` is high at a rising edge, the count becomes 1 and the step store is reloaded so that entry k holds 1 for even k and 2 for odd k. The first step taken after reset is therefore +1.
- R2: After reset, with no load and before the count wraps, the output is never a multiple of 3. The sequence is 1, 2, 4, 5, 7, 8, 10, 11, and so on.
- R3: On an edge with `enable` high, `loadEn` low and `rst` low, the count increases by the front step, and the store rotates so that entry k+1 becomes the new front (modulo DEPTH).
- R4: On an edge with `enable`, `loadEn` and `rst` all low, the count and the step phase both stay unchanged.
- R5: On an edge with `loadEn` high and `rst` low, the count becomes `loadStart` and no step is added. Entry k of the store takes `loadPattern[k*STEP_W +: STEP_W]`, where STEP_W = ceil(log2(DEPTH+2)).
- R6: The first step taken after a load is entry 0 of the loaded pattern. Later steps follow the entries in index order and repeat.
- R7: `rst` takes priority over both `loadEn` and `enable`.
- R8: The count wraps modulo 2^WIDTH with no special handling.
- R9: When `loadEn` and `enable` are high together, the load wins and the count does not advance in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Advance the count and rotate the step store |
| loadEn | input | 1 | Replace the step store and the count |
| loadPattern | input | DEPTH*STEP_W | New steps; entry 0 is in the lowest bits |
| loadStart | input | WIDTH | Count value taken on a load |
| count | output | WIDTH | Current counter value |

## Verification
The assertions assume that `rst` is high at the first clock edge, so that the store and the count start from known values. They also assume that the control inputs are never X at a clock edge. The stimulus raises reset from time zero and drives all inputs to defined values on falling edges. It includes cycles in which reset, load and enable are high together. The residue checks are applied only where the reference sequence cannot wrap.

// File: rtl/skip_counter_pkg.sv
package skip_counter_pkg;
  // Strobes from the control block to the datapath; at most one is high.
  typedef struct packed {
    logic restart;
    logic loadStart;
    logic advance;
  } ctrl_strobe_t;
endpackage

// File: rtl/skip_counter_ctrl.sv
module skip_counter_ctrl
  import skip_counter_pkg::*;
#(
  parameter int DEPTH  = 2,
  parameter int STEP_W = $clog2(DEPTH + 2)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      enable,
  input  logic                      loadEn,
  input  logic [DEPTH*STEP_W-1:0]   loadPattern,
  output ctrl_strobe_t              strobe,
  output logic [STEP_W-1:0]         headStep
);
  localparam logic [STEP_W-1:0] STEP_ONE = STEP_W'(1);
  localparam logic [STEP_W-1:0] STEP_TWO = STEP_W'(2);

  logic [STEP_W-1:0] ring [DEPTH];

  // Priority: reset, then load, then advance.
  always_comb begin
    strobe.restart   = rst;
    strobe.loadStart = !rst && loadEn;
    strobe.advance   = !rst && !loadEn && enable;
  end

  genvar i;
  generate
    for (i = 0; i < DEPTH; i++) begin : g_ring
      localparam logic [STEP_W-1:0] DFLT = ((i % 2) == 0) ? STEP_ONE : STEP_TWO;
      localparam int NEXT = (i + 1) % DEPTH;
      always_ff @(posedge clk) begin
        if (strobe.restart)        ring[i] <= DFLT;
        else if (strobe.loadStart) ring[i] <= loadPattern[i*STEP_W +: STEP_W];
        else if (strobe.advance)   ring[i] <= ring[NEXT];
      end
    end
  endgenerate

  assign headStep = ring[0];

  // R1
  reset_head_chk: assert property (@(posedge clk) rst |=> headStep == STEP_ONE);
  // R3
  rotate_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && !loadEn) |=> headStep == $past(ring[1 % DEPTH]));
  // R6
  load_head_chk: assert property (@(posedge clk) disable iff (rst)
    loadEn |=> headStep == $past(loadPattern[STEP_W-1:0]));
  // R4
  hold_phase_chk: assert property (@(posedge clk) disable iff (rst)
    (!enable && !loadEn) |=> $stable(headStep));
endmodule

// File: rtl/skip_counter_dp.sv
module skip_counter_dp
  import skip_counter_pkg::*;
#(
  parameter int WIDTH  = 16,
  parameter int STEP_W = 2
) (
  input  logic              clk,
  input  ctrl_strobe_t      strobe,
  input  logic [STEP_W-1:0] step,
  input  logic [WIDTH-1:0]  loadValue,
  output logic [WIDTH-1:0]  count
);
  localparam logic [WIDTH-1:0] START = WIDTH'(1);

  logic [WIDTH-1:0] stepWide;
  logic [WIDTH-1:0] sumNext;

  assign stepWide = {{(WIDTH-STEP_W){1'b0}}, step};
  assign sumNext  = count + stepWide;  // the only adder; wraps naturally

  always_ff @(posedge clk) begin
    if (strobe.restart)        count <= START;
    else if (strobe.loadStart) count <= loadValue;
    else if (strobe.advance)   count <= sumNext;
  end

  // R1
  reset_value_chk: assert property (@(posedge clk) strobe.restart |=> count == START);
  // R5
  load_value_chk: assert property (@(posedge clk) disable iff (strobe.restart)
    strobe.loadStart |=> count == $past(loadValue));
  // R4
  hold_count_chk: assert property (@(posedge clk) disable iff (strobe.restart)
    (!strobe.advance && !strobe.loadStart) |=> $stable(count));
endmodule

// File: rtl/skip_counter.sv
module skip_counter
  import skip_counter_pkg::*;
#(
  parameter int WIDTH  = 16,
  parameter int DEPTH  = 2,
  parameter int STEP_W = $clog2(DEPTH + 2)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    enable,
  input  logic                    loadEn,
  input  logic [DEPTH*STEP_W-1:0] loadPattern,
  input  logic [WIDTH-1:0]        loadStart,
  output logic [WIDTH-1:0]        count
);
  ctrl_strobe_t      strobe;
  logic [STEP_W-1:0] headStep;

  skip_counter_ctrl #(.DEPTH(DEPTH), .STEP_W(STEP_W)) u_ctrl (
    .clk(clk), .rst(rst), .enable(enable), .loadEn(loadEn),
    .loadPattern(loadPattern), .strobe(strobe), .headStep(headStep)
  );

  skip_counter_dp #(.WIDTH(WIDTH), .STEP_W(STEP_W)) u_dp (
    .clk(clk), .strobe(strobe), .step(headStep),
    .loadValue(loadStart), .count(count)
  );

  // R7
  strobe_excl_chk: assert property (@(posedge clk)
    $onehot0({strobe.restart, strobe.loadStart, strobe.advance}));
endmodule

// File: tb/skip_counter_tb.sv
module skip_counter_tb;
  localparam int WIDTH  = 16;
  localparam int DEPTH  = 4;
  localparam int STEP_W = $clog2(DEPTH + 2);
  localparam int PW     = DEPTH * STEP_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0;
  logic loadEn = 1'b0;
  logic [PW-1:0] loadPattern = '0;
  logic [WIDTH-1:0] loadStart = '0;
  logic [WIDTH-1:0] count;

  always #2 clk = ~clk;  // 250 MHz

  skip_counter #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .enable(enable), .loadEn(loadEn),
    .loadPattern(loadPattern), .loadStart(loadStart), .count(count)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [WIDTH-1:0] expQ[$];
  string tagQ[$];
  int modQ[$];

  logic [WIDTH-1:0] refCount = '0;
  int refPat[DEPTH];
  int refIdx = 0;

  localparam logic [PW-1:0] PAT_DEFAULT = {3'd2, 3'd1, 3'd2, 3'd1};
  localparam logic [PW-1:0] PAT_SKIP5   = {3'd2, 3'd1, 3'd1, 3'd1};

  // Driver: sets inputs for the next edge and pushes the expected result.
  task automatic drive(input bit r, input bit en, input bit ld,
                       input logic [PW-1:0] pat, input logic [WIDTH-1:0] st,
                       input string tag, input int modN);
    @(negedge clk);
    rst = r; enable = en; loadEn = ld; loadPattern = pat; loadStart = st;
    if (r) begin
      refCount = 1;
      for (int k = 0; k < DEPTH; k++) refPat[k] = (k % 2 == 0) ? 1 : 2;
      refIdx = 0;
    end else if (ld) begin
      refCount = st;
      for (int k = 0; k < DEPTH; k++) refPat[k] = int'(pat[k*STEP_W +: STEP_W]);
      refIdx = 0;
    end else if (en) begin
      refCount = WIDTH'(int'(refCount) + refPat[refIdx]);
      refIdx = (refIdx + 1) % DEPTH;
    end
    expQ.push_back(refCount);
    tagQ.push_back(tag);
    modQ.push_back(modN);
  endtask

  // Monitor: compares just after each rising edge.
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      logic [WIDTH-1:0] e;
      string t;
      int m;
      e = expQ.pop_front(); t = tagQ.pop_front(); m = modQ.pop_front();
      checks++;
      if (count !== e) begin
        errors++;
        $display("FAIL %s count actual %0d expected %0d", t, count, e);
      end
      if (m > 0) begin
        checks++;
        if ((int'(count) % m) == 0) begin
          errors++;
          $display("FAIL R2 residue mod %0d actual %0d expected nonzero", m, int'(count) % m);
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1 reset state
    for (int i = 0; i < 3; i++) drive(1, 0, 0, '0, '0, "R1", 0);
    // R2/R3 default run with R4 stalls
    for (int i = 0; i < 3000; i++) begin
      bit en = (i % 97) < 94;
      drive(0, en, 0, '0, '0, en ? "R3" : "R4", 3);
    end
    // R7 reset wins over load and enable
    drive(1, 1, 1, PAT_SKIP5, 16'd500, "R7", 0);
    for (int i = 0; i < 6; i++) drive(0, 1, 0, '0, '0, "R2", 3);
    // R9 load with enable high: no advance in the load cycle
    drive(0, 1, 1, PAT_SKIP5, 16'd1, "R9", 0);
    // R6 first step after load is entry 0; then the skip-5 run
    drive(0, 1, 0, '0, '0, "R6", 5);
    for (int i = 0; i < 3000; i++) begin
      bit en = (i % 53) < 50;
      drive(0, en, 0, '0, '0, en ? "R5" : "R4", 5);
    end
    // R5 load with enable low, then hold
    drive(0, 0, 1, PAT_DEFAULT, 16'd100, "R5", 0);
    for (int i = 0; i < 3; i++) drive(0, 0, 0, '0, '0, "R4", 0);
    for (int i = 0; i < 8; i++) drive(0, 1, 0, '0, '0, "R6", 3);
    // R8 wrap at the top of the range
    drive(0, 1, 1, PAT_DEFAULT, 16'd65533, "R8", 0);
    for (int i = 0; i < 6; i++) drive(0, 1, 0, '0, '0, "R8", 0);
    // back to reset
    drive(1, 0, 0, '0, '0, "R1", 0);
    for (int i = 0; i < 4; i++) drive(0, 1, 0, '0, '0, "R2", 3);
    drive(0, 0, 0, '0, '0, "R4", 0);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule